// File: doc/BRIEF.md
# MCU Clock Output Controller

This block drives a clock pin for an external microcontroller. The source is a fast crystal-domain reference clock (nominally 30 MHz), or a separate low-power clock (nominally 32.768 kHz). A 3-bit select picks one of seven divided-down rates of the reference, or the low-power clock itself. The output is built from half-cycles of the reference. This allows division by 1, by 7.5 and by odd ratios with a clean, registered waveform.

Three inputs set what the output does when the chip goes to sleep: a low-frequency enable, a 2-bit tail setting and a pending-interrupt flag.
- If the low-frequency enable is set, the pin falls back to the low-power clock during sleep.
- If it is clear, the pin delivers a programmed number of further rising edges and then holds low.
- A pending interrupt keeps the selected clock running and postpones sleep until the interrupt is cleared.

Every change of source or divisor waits until the pin is low, so no high pulse is ever cut short. All inputs except the low-power clock belong to the reference domain. The low-power clock is synchronised internally.

Top module: `mcu_clkout`

## Requirements
- R1: While `rst` is high the output is low. After reset, with a control word of zero, the output runs at the reference rate: one half-cycle high and one half-cycle low per period.
- R2: With the select awake and below 111, the output period measured in reference half-cycles is: 000→2, 001→4, 010→6, 011→15, 100→20, 101→30, 110→60. The high time is the floor of half the period.
- R3: Select 111 while awake makes the output follow the synchronised low-power clock, with the same period and high time.
- R4: In sleep with the low-frequency enable set and no interrupt pending, the output follows the low-power clock whatever the select is. Once sleep ends, the selected rate returns.
- R5: In sleep with the low-frequency enable clear and no interrupt pending, the output gives exactly 0, 128, 256 or 512 further rising edges for tail codes 00, 01, 10, 11, then stays low. Counting starts at the first reference edge that sees the sleep request.
- R6: While an interrupt is pending, the output keeps running at the selected rate and sleep is deferred. Sleep handling starts once the interrupt flag clears.
- R7: When sleep ends, the selected rate resumes. Each new sleep entry reloads the full tail count.
- R8: A change of source or divisor takes effect only while the output is low. A high pulse in progress always completes at its full length.
- R9: Control word layout: bits 5:4 tail code, bit 3 low-frequency enable, bits 2:0 rate select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-domain reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_clk | input | 1 | Low-power slow clock, asynchronous to `clk` |
| ctrl_word | input | 6 | {tail[1:0], lf_enable, rate_select[2:0]} |
| sleep_req | input | 1 | Sleep mode requested |
| irq_pending | input | 1 | An unread interrupt is outstanding |
| mcu_clk | output | 1 | Clock delivered to the microcontroller |

## Verification
Four properties are checked on every cycle:
- the active source or divisor changes only after a low half-cycle;
- a pending interrupt always leaves a running source;
- sleep with the low-frequency enable forces the slow source as soon as the output is low;
- the output is stopped only under valid sleep conditions.

Only the bench scenarios can show the following:
- the exact period and high time for each select value, including the 7.5 ratio;
- the exact rising-edge counts delivered by each tail code;
- that a long high pulse in progress completes intact across a switch;
- that the rate returns correctly after wake.

// File: rtl/mcu_clk_pkg.sv
`timescale 1ns/1ps
package mcu_clk_pkg;

  // Phase counter width in reference half-cycles (longest period is 60).
  localparam int PH_W = 7;

  typedef enum logic [1:0] {
    SRC_DIV = 2'd0,
    SRC_LF  = 2'd1,
    SRC_OFF = 2'd2
  } src_e;

  // Output period, in reference half-cycles, for each divided select value.
  function automatic logic [PH_W-1:0] half_len(input logic [2:0] sel);
    case (sel)
      3'd0:    half_len = PH_W'(2);
      3'd1:    half_len = PH_W'(4);
      3'd2:    half_len = PH_W'(6);
      3'd3:    half_len = PH_W'(15);
      3'd4:    half_len = PH_W'(20);
      3'd5:    half_len = PH_W'(30);
      default: half_len = PH_W'(60);
    endcase
  endfunction

endpackage

// File: rtl/mcu_clk_sync.sv
`timescale 1ns/1ps
module mcu_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/mcu_clk_halfdiv.sv
`timescale 1ns/1ps
// Walks the output waveform two half-cycles per reference cycle.
// a_n is the level for the high phase of clk, b_n for the low phase.
module mcu_clk_halfdiv
  import mcu_clk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [PH_W-1:0] len,
  output logic            a_n,
  output logic            b_n
);
  localparam logic [PH_W:0] ONE = (PH_W+1)'(1);
  localparam logic [PH_W:0] TWO = (PH_W+1)'(2);

  logic [PH_W-1:0] ph_q, ph0, ph1, ph2, half;
  logic [PH_W:0]   s1, s2, lw;

  always_comb begin
    ph0  = restart ? '0 : ph_q;
    half = len >> 1;
    lw   = {1'b0, len};
    s1   = {1'b0, ph0} + ONE;
    s2   = {1'b0, ph0} + TWO;
    ph1  = (s1 >= lw) ? PH_W'(s1 - lw) : s1[PH_W-1:0];
    ph2  = (s2 >= lw) ? PH_W'(s2 - lw) : s2[PH_W-1:0];
    a_n  = (ph0 < half);
    b_n  = (ph1 < half);
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph2;
  end
endmodule

// File: rtl/mcu_clk_tail.sv
`timescale 1ns/1ps
// Counts remaining output rising edges during a stopping sleep.
module mcu_clk_tail #(
  parameter int TAIL_UNIT = 128,
  parameter int TAIL_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_on,
  input  logic [1:0]        tail_sel,
  input  logic              rise,
  output logic [TAIL_W-1:0] avail
);
  logic              on_q;
  logic [TAIL_W-1:0] rem_q, load;

  always_comb begin
    case (tail_sel)
      2'd0:    load = '0;
      2'd1:    load = TAIL_W'(TAIL_UNIT);
      2'd2:    load = TAIL_W'(TAIL_UNIT * 2);
      default: load = TAIL_W'(TAIL_UNIT * 4);
    endcase
  end

  // A fresh sleep entry sees the full reload in the same cycle.
  assign avail = (sleep_on && !on_q) ? load : rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      rem_q <= '0;
    end else begin
      on_q <= sleep_on;
      if (!sleep_on)                 rem_q <= '0;
      else if (rise && avail != '0)  rem_q <= avail - TAIL_W'(1);
      else                           rem_q <= avail;
    end
  end
endmodule

// File: rtl/mcu_clk_ddr.sv
`timescale 1ns/1ps
// Two-edge output stage: out = p ^ n, and only one flop changes per edge.
module mcu_clk_ddr (
  input  logic clk,
  input  logic rst,
  input  logic a_n,
  input  logic b_now,
  output logic out
);
  logic p_q, n_q;

  always_ff @(posedge clk) begin
    if (rst) p_q <= 1'b0;
    else     p_q <= a_n ^ n_q;
  end

  always_ff @(negedge clk) begin
    if (rst) n_q <= 1'b0;
    else     n_q <= b_now ^ p_q;
  end

  assign out = p_q ^ n_q;
endmodule

// File: rtl/mcu_clkout.sv
`timescale 1ns/1ps
module mcu_clkout
  import mcu_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TAIL_UNIT   = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lf_clk,
  input  logic [5:0] ctrl_word,
  input  logic       sleep_req,
  input  logic       irq_pending,
  output logic       mcu_clk
);
  localparam int TAIL_W = $clog2(TAIL_UNIT * 4 + 1);

  logic [2:0]        sel;
  logic              lf_en;
  logic [1:0]        tail_sel;
  logic              lf_s, eff_sleep;
  src_e              sel_src, des_src, act_src_q, nxt_src;
  logic [PH_W-1:0]   des_len, act_len_q, nxt_len;
  logic              commit, div_a, div_b, src_a, src_b, rise;
  logic              b_q;
  logic [TAIL_W-1:0] avail;

  assign sel      = ctrl_word[2:0];
  assign lf_en    = ctrl_word[3];
  assign tail_sel = ctrl_word[5:4];

  mcu_clk_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(lf_clk), .q(lf_s)
  );

  // A pending interrupt defers sleep entirely.
  assign eff_sleep = sleep_req && !irq_pending;
  assign sel_src   = (sel == 3'b111) ? SRC_LF : SRC_DIV;

  always_comb begin
    if (!eff_sleep)         des_src = sel_src;
    else if (lf_en)         des_src = SRC_LF;
    else if (avail != '0)   des_src = sel_src;
    else                    des_src = SRC_OFF;
    des_len = (des_src == SRC_DIV) ? half_len(sel) : act_len_q;
  end

  // Switch only when the last driven half-cycle was low.
  assign commit  = ((des_src != act_src_q) || (des_len != act_len_q)) && !b_q;
  assign nxt_src = commit ? des_src : act_src_q;
  assign nxt_len = commit ? des_len : act_len_q;

  mcu_clk_halfdiv div_i (
    .clk(clk), .rst(rst),
    .restart(commit && des_src == SRC_DIV),
    .len(nxt_len), .a_n(div_a), .b_n(div_b)
  );

  always_comb begin
    case (nxt_src)
      SRC_DIV: begin src_a = div_a; src_b = div_b; end
      SRC_LF:  begin src_a = lf_s;  src_b = lf_s;  end
      default: begin src_a = 1'b0;  src_b = 1'b0;  end
    endcase
  end

  assign rise = (!b_q && src_a) || (!src_a && src_b);

  mcu_clk_tail #(.TAIL_UNIT(TAIL_UNIT), .TAIL_W(TAIL_W)) tail_i (
    .clk(clk), .rst(rst), .sleep_on(eff_sleep),
    .tail_sel(tail_sel), .rise(rise), .avail(avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_src_q <= SRC_DIV;
      act_len_q <= half_len(3'd0);
      b_q       <= 1'b0;
    end else begin
      act_src_q <= nxt_src;
      act_len_q <= nxt_len;
      b_q       <= src_b;
    end
  end

  mcu_clk_ddr ddr_i (
    .clk(clk), .rst(rst), .a_n(src_a), .b_now(b_q), .out(mcu_clk)
  );
endmodule

// File: rtl/mcu_clkout_chk.sv
`timescale 1ns/1ps
module mcu_clkout_chk
  import mcu_clk_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [5:0]      ctrl_word,
  input logic            sleep_req,
  input logic            irq_pending,
  input logic [1:0]      act_src,
  input logic [PH_W-1:0] act_len,
  input logic            b_q
);
  logic armed_q;
  always_ff @(posedge clk) armed_q <= !rst;

  // R8: source or divisor changes only after a low half-cycle
  assert_switch_when_low_R8: assert property (@(posedge clk) disable iff (rst)
    (armed_q && (!$stable(act_src) || !$stable(act_len))) |-> !$past(b_q));

  // R6: a pending interrupt always yields a running source
  assert_irq_keeps_clock_R6: assert property (@(posedge clk) disable iff (rst)
    irq_pending |=> (act_src != SRC_OFF));

  // R4: low-frequency sleep selects the slow source once the output is low
  assert_lf_in_sleep_R4: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && ctrl_word[3] && !irq_pending && !b_q) |=> (act_src == SRC_LF));

  // R5: stopping only happens under stop-type sleep
  assert_stop_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (armed_q && act_src == SRC_OFF && $past(act_src) != SRC_OFF)
      |-> $past(sleep_req && !ctrl_word[3] && !irq_pending));
endmodule

bind mcu_clkout mcu_clkout_chk chk_i (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .sleep_req(sleep_req),
  .irq_pending(irq_pending), .act_src(act_src_q), .act_len(act_len_q),
  .b_q(b_q)
);

// File: tb/mcu_clkout_tb_top.sv
`timescale 1ns/1ps
module mcu_clkout_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lf_clk = 1'b0;
  logic [5:0] ctrl_word = '0;
  logic       sleep_req = 1'b0;
  logic       irq_pending = 1'b0;
  logic       mcu_clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int per_t [7] = '{2, 4, 6, 15, 20, 30, 60};

  always #10 clk = ~clk;

  // Slow clock: 40 reference cycles per half, so 160 half-cycles per period.
  initial forever begin
    repeat (40) @(negedge clk);
    lf_clk = ~lf_clk;
  end

  mcu_clkout dut_i (
    .clk(clk), .rst(rst), .lf_clk(lf_clk), .ctrl_word(ctrl_word),
    .sleep_req(sleep_req), .irq_pending(irq_pending), .mcu_clk(mcu_clk)
  );

  // R9: {tail, lf_enable, select}
  function automatic logic [5:0] mk(input logic [1:0] t, input logic lf, input logic [2:0] s);
    return {t, lf, s};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic get_half(output logic v);
    @(clk);
    #2;
    v = mcu_clk;
  endtask

  task automatic measure(output int hi, output int per);
    logic v, pv;
    int lo;
    get_half(pv);
    for (int i = 0; i < 4000; i++) begin
      get_half(v);
      if (!pv && v) break;
      pv = v;
    end
    hi = 1;
    lo = 0;
    for (int i = 0; i < 4000; i++) begin
      get_half(v);
      if (!v) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 4000; i++) begin
      get_half(v);
      if (v) break;
      lo++;
    end
    per = hi + lo;
  endtask

  task automatic expect_freq(input string req, input int exp_hi, input int exp_per);
    int hi, per;
    measure(hi, per);
    measure(hi, per);
    check(hi == exp_hi, req, hi, exp_hi);
    check(per == exp_per, req, per, exp_per);
  endtask

  task automatic count_rises(input int halves, output int rises, output int last_hi);
    logic v, pv;
    @(negedge clk);
    #2;
    pv = mcu_clk;
    sleep_req = 1'b1;
    irq_pending = 1'b0;
    rises = 0;
    last_hi = -1;
    for (int i = 0; i < halves; i++) begin
      get_half(v);
      if (!pv && v) rises++;
      if (v) last_hi = i;
      pv = v;
    end
  endtask

  // R5 / R7: tail edge count, then wake and confirm rate returns
  task automatic tail_run(input logic [2:0] s, input logic [1:0] t, input int exp);
    int rises, last_hi, bound;
    ctrl_word = mk(t, 1'b0, s);
    sleep_req = 1'b0;
    expect_freq("R7", per_t[s] / 2, per_t[s]);
    bound = exp * per_t[s] + per_t[s] + 300;
    count_rises(bound, rises, last_hi);
    check(rises == exp, "R5", rises, exp);
    check(last_hi < bound - 200, "R5", last_hi, bound - 200);
    sleep_req = 1'b0;
    expect_freq("R7", per_t[s] / 2, per_t[s]);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic v;
    int hi, rises, last_hi;
    // R1: output low in reset
    repeat (4) @(posedge clk);
    get_half(v); check(v == 1'b0, "R1", v, 0);
    get_half(v); check(v == 1'b0, "R1", v, 0);
    @(negedge clk);
    rst = 1'b0;
    expect_freq("R1", 1, 2);

    // R2 sweep; R4: the enable has no effect while awake
    for (int lf = 0; lf < 2; lf++) begin
      for (int s = 0; s < 7; s++) begin
        ctrl_word = mk(2'd0, lf[0], s[2:0]);
        expect_freq(lf == 0 ? "R2" : "R4", per_t[s] / 2, per_t[s]);
      end
    end

    // R3: select 111 awake follows slow clock
    ctrl_word = mk(2'd0, 1'b0, 3'b111);
    expect_freq("R3", 80, 160);

    // R4: low-frequency sleep overrides select
    for (int k = 0; k < 3; k++) begin
      int s = k * 3;
      ctrl_word = mk(2'd0, 1'b1, s[2:0]);
      sleep_req = 1'b1;
      expect_freq("R4", 80, 160);
      sleep_req = 1'b0;
      expect_freq("R7", per_t[s] / 2, per_t[s]);
    end

    // R5: tail codes
    tail_run(3'd0, 2'd0, 0);
    tail_run(3'd0, 2'd1, 128);
    tail_run(3'd0, 2'd2, 256);
    tail_run(3'd0, 2'd3, 512);
    tail_run(3'd3, 2'd1, 128);
    tail_run(3'd5, 2'd2, 256);

    // R6: interrupt defers sleep
    ctrl_word = mk(2'd0, 1'b0, 3'd1);
    irq_pending = 1'b1;
    sleep_req = 1'b1;
    expect_freq("R6", 2, 4);
    count_rises(200, rises, last_hi);  // clears irq, keeps sleep
    check(rises == 0, "R6", rises, 0);
    sleep_req = 1'b0;
    expect_freq("R7", 2, 4);

    // R8: slow high pulse completes across a switch to the fastest rate
    ctrl_word = mk(2'd0, 1'b0, 3'd6);
    expect_freq("R8", 30, 60);
    begin
      logic pv;
      get_half(pv);
      for (int i = 0; i < 200; i++) begin
        get_half(v);
        if (!pv && v) break;
        pv = v;
      end
      hi = 1;
      for (int i = 0; i < 3; i++) begin get_half(v); if (v) hi++; end
      ctrl_word = mk(2'd0, 1'b0, 3'd0);
      for (int i = 0; i < 200; i++) begin get_half(v); if (!v) break; hi++; end
      check(hi == 30, "R8", hi, 30);
    end
    expect_freq("R8", 1, 2);

    // R8: slow-clock high pulse completes before returning to a divider
    ctrl_word = mk(2'd0, 1'b0, 3'b111);
    expect_freq("R3", 80, 160);
    begin
      logic pv;
      get_half(pv);
      for (int i = 0; i < 400; i++) begin
        get_half(v);
        if (!pv && v) break;
        pv = v;
      end
      hi = 1;
      for (int i = 0; i < 5; i++) begin get_half(v); if (v) hi++; end
      ctrl_word = mk(2'd0, 1'b0, 3'd0);
      for (int i = 0; i < 400; i++) begin get_half(v); if (!v) break; hi++; end
      check(hi == 80, "R8", hi, 80);
    end
    expect_freq("R8", 1, 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule